// File: doc/BRIEF.md
# Interval Timer Host Register Front End

This block is the byte-wide register interface that sits between a host bus and a three-channel interval timer. The bus has four byte addresses. Addresses 0 to 2 are the channel data ports and address 3 is the control port. Control words set up a channel's byte access order, its counting mode and its BCD flag. Other control words freeze a snapshot of a channel's count, or run a read-back command that can freeze the count and/or the status of several channels at once.

Data writes are assembled into a 16-bit initial count. The count goes to the channel together with a one-cycle load strobe. Data reads return, in priority order: a frozen status byte, then a frozen count byte, then a byte of the channel's live count. The counting engines are outside this block. Each engine gets its initial count, load strobe, mode and BCD bit from here, and returns its live count and output level.

The bus is single-cycle. The address, strobes and write data are sampled on a rising clock edge. Read data and the unused flag are combinational from the current state while the read strobe is high. Every side effect of a read, such as freeing a latch or advancing the byte order, takes place at the clock edge that samples the read strobe.

Each channel holds three state machines:
- **Write order:** `SEQ_FIRST` → `SEQ_SECOND` on the first data write in low-then-high access. It returns to `SEQ_FIRST` on the second write or on a control word.
- **Live read order:** `SEQ_FIRST` ⇄ `SEQ_SECOND` on each live read in low-then-high access. It returns to `SEQ_FIRST` on a control word.
- **Count latch:**
  - A latch command moves `CL_IDLE` to `CL_ONE_LO` (low-only access), `CL_ONE_HI` (high-only access) or `CL_PAIR_LO` (low-then-high access).
  - A read of a frozen byte moves `CL_PAIR_LO` to `CL_ONE_HI`, and moves `CL_ONE_LO` or `CL_ONE_HI` back to `CL_IDLE`.

Top module: `tmr_host_regs`

## Requirements
- R1: A control word at address 3 is decoded by field:
  - Bits 7:6 pick the channel; the value 11 means read-back.
  - Bits 5:4 give the access: 00 count latch, 01 low byte only, 10 high byte only, 11 low then high.
  - Bits 3:1 give the mode and bit 0 the BCD flag.
  - A non-zero access field stores the access, mode and BCD flag for the channel, and returns its read and write byte orders to the first byte.
  - `ch_mode` and `ch_bcd` show the stored values from the cycle after the write.
- R2: In low-only access a data write loads {8'h00, byte}; in high-only access it loads {byte, 8'h00`}. The loaded value is on `ch_init_count` and `ch_load` pulses for that one channel in the cycle after the write.
- R3: In low-then-high access, the first data write is held and produces no load. The second write loads {second byte, first byte}.
- R4: With no latch pending, a data read returns the live count. Low-only access gives the low byte and high-only access gives the high byte. Low-then-high access alternates low, high, low, and so on, starting with low after a control word.
- R5: A count latch command freezes the live count. Frozen bytes are read out in the channel's access order: one byte, or low then high. After the last frozen byte is read, reads return the live count again.
- R6: A count latch command that arrives while frozen bytes remain unread is ignored.
- R7: A read-back word (bits 7:6 = 11) applies to the channels selected by bits 1, 2 and 3 (channels 0, 1 and 2):
  - Bit 5 = 0 freezes the count of each selected channel.
  - Bit 4 = 0 freezes the status of each selected channel, unless a status byte is already waiting there.
  - Channels that are not selected are untouched.
- R8: The status byte holds the output level in bit 7, 0 in bit 6, the access in bits 5:4, the mode in bits 3:1 and BCD in bit 0. On a data read, a waiting status byte comes before frozen count bytes, and frozen count bytes come before the live count.
- R9: A read of address 3 returns 8'hFF with `bus_rd_unused` high and changes no state; all other reads leave `bus_rd_unused` low.
- R10: Reset gives every channel:
  - low-only access, mode 0 and BCD 0;
  - no frozen count or status;
  - both byte orders at the first byte;
  - an initial count of 0 and `ch_load` low.
- R11: `ch_mode` and `ch_bcd` change only in the cycle after a control-port write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Byte address: 0..NCH-1 data ports, 2**AW-1 control port |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; read side effects happen at the edge that samples it |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational while `bus_rd` is high |
| bus_rd_unused | output | 1 | High while reading an address with no channel behind it |
| ch_init_count | output | NCH*16 | Initial count per channel (channel i at bits 16i+15:16i) |
| ch_load | output | NCH | One-cycle load strobe per channel |
| ch_mode | output | NCH*3 | Counting mode per channel |
| ch_bcd | output | NCH | BCD flag per channel |
| ch_live_count | input | NCH*16 | Live count from each counting engine |
| ch_out | input | NCH | Output level from each counting engine |

## Verification
The bench builds the block with NCH = 3 and AW = 2. With these values each of the three read-back select bits reaches a real channel, and address 3 is both the control port and the one data address with no channel. A counter model in the bench loads on `ch_load` and, when enabled, counts down every cycle. Because the live count moves while a latch is pending, a frozen count can be told apart from the live count, and a second latch command that was wrongly accepted would also show up. The bench also checks status-before-count priority, selective read-back, and the return of both byte orders to the first byte after a control word.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;

    localparam logic [1:0] RB_CODE = 2'b11;

    // Access field of a control word
    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_WORD  = 2'b11
    } acc_e;

    // Byte order position for read and write sequences
    typedef enum logic {
        SEQ_FIRST  = 1'b0,
        SEQ_SECOND = 1'b1
    } seq_e;

    // Frozen-count read state
    typedef enum logic [1:0] {
        CL_IDLE    = 2'd0,
        CL_ONE_LO  = 2'd1,
        CL_ONE_HI  = 2'd2,
        CL_PAIR_LO = 2'd3
    } clat_e;
endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode
    import tmr_pkg::*;
#(
    parameter int NCH = 3,
    parameter int AW  = 2
) (
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [NCH-1:0]    cfg_we,
    output acc_e              cfg_acc,
    output logic [MODE_W-1:0] cfg_mode,
    output logic              cfg_bcd,
    output logic [NCH-1:0]    cnt_latch,
    output logic [NCH-1:0]    sts_latch,
    output logic [NCH-1:0]    data_we,
    output logic [NCH-1:0]    data_re,
    output logic              rd_unused
);
    localparam logic [AW-1:0] CTRL_ADDR  = {AW{1'b1}};
    localparam logic [AW-1:0] FIRST_FREE = AW'(NCH);

    logic       ctl_wr;
    logic       rb_cmd;
    logic [1:0] sel_field;
    acc_e       acc_field;

    assign ctl_wr    = bus_wr && (bus_addr == CTRL_ADDR);
    assign sel_field = bus_wdata[7:6];
    assign acc_field = acc_e'(bus_wdata[5:4]);
    assign rb_cmd    = ctl_wr && (sel_field == RB_CODE);

    assign cfg_acc   = acc_field;
    assign cfg_mode  = bus_wdata[3:1];
    assign cfg_bcd   = bus_wdata[0];
    assign rd_unused = bus_rd && (bus_addr >= FIRST_FREE);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam logic [1:0]    CH_CODE = 2'(i);
        localparam logic [AW-1:0] CH_ADDR = AW'(i);
        logic direct;
        logic rb_pick;

        assign direct       = ctl_wr && (sel_field == CH_CODE);
        assign rb_pick      = rb_cmd && bus_wdata[1+i];
        assign cfg_we[i]    = direct && (acc_field != ACC_LATCH);
        assign cnt_latch[i] = (direct && (acc_field == ACC_LATCH)) ||
                              (rb_pick && !bus_wdata[5]);
        assign sts_latch[i] = rb_pick && !bus_wdata[4];
        assign data_we[i]   = bus_wr && (bus_addr == CH_ADDR);
        assign data_re[i]   = bus_rd && (bus_addr == CH_ADDR);
    end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  acc_e              cfg_acc,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic              cfg_bcd,
    input  logic              cnt_latch_req,
    input  logic              sts_latch_req,
    input  logic              data_we,
    input  logic              data_re,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live_count,
    input  logic              out_lvl,
    output logic [CNT_W-1:0]  init_count,
    output logic              load_stb,
    output logic [MODE_W-1:0] mode,
    output logic              bcd,
    output logic [BYTE_W-1:0] rd_byte
);
    acc_e              acc_q,   acc_d;
    logic [MODE_W-1:0] mode_q,  mode_d;
    logic              bcd_q,   bcd_d;
    seq_e              wseq_q,  wseq_d;
    seq_e              rseq_q,  rseq_d;
    logic [BYTE_W-1:0] hold_q,  hold_d;
    clat_e             cl_q,    cl_d;
    logic [CNT_W-1:0]  snap_q,  snap_d;
    logic              stv_q,   stv_d;
    logic [BYTE_W-1:0] sts_q,   sts_d;
    logic [CNT_W-1:0]  init_q,  init_d;
    logic              load_q,  load_d;

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= ACC_LO;
            mode_q <= '0;
            bcd_q  <= 1'b0;
            wseq_q <= SEQ_FIRST;
            rseq_q <= SEQ_FIRST;
            hold_q <= '0;
            cl_q   <= CL_IDLE;
            snap_q <= '0;
            stv_q  <= 1'b0;
            sts_q  <= '0;
            init_q <= '0;
            load_q <= 1'b0;
        end else begin
            acc_q  <= acc_d;
            mode_q <= mode_d;
            bcd_q  <= bcd_d;
            wseq_q <= wseq_d;
            rseq_q <= rseq_d;
            hold_q <= hold_d;
            cl_q   <= cl_d;
            snap_q <= snap_d;
            stv_q  <= stv_d;
            sts_q  <= sts_d;
            init_q <= init_d;
            load_q <= load_d;
        end
    end

    // Next-state process
    always_comb begin
        acc_d  = acc_q;
        mode_d = mode_q;
        bcd_d  = bcd_q;
        wseq_d = wseq_q;
        rseq_d = rseq_q;
        hold_d = hold_q;
        cl_d   = cl_q;
        snap_d = snap_q;
        stv_d  = stv_q;
        sts_d  = sts_q;
        init_d = init_q;
        load_d = 1'b0;

        if (cfg_we) begin
            acc_d  = cfg_acc;
            mode_d = cfg_mode;
            bcd_d  = cfg_bcd;
            wseq_d = SEQ_FIRST;
            rseq_d = SEQ_FIRST;
        end

        if (data_we) begin
            unique case (acc_q)
                ACC_HI: begin
                    init_d = {wdata, {BYTE_W{1'b0}}};
                    load_d = 1'b1;
                end
                ACC_WORD: begin
                    unique case (wseq_q)
                        SEQ_FIRST: begin
                            hold_d = wdata;
                            wseq_d = SEQ_SECOND;
                        end
                        SEQ_SECOND: begin
                            init_d = {wdata, hold_q};
                            load_d = 1'b1;
                            wseq_d = SEQ_FIRST;
                        end
                    endcase
                end
                default: begin
                    init_d = {{BYTE_W{1'b0}}, wdata};
                    load_d = 1'b1;
                end
            endcase
        end

        if (cnt_latch_req && (cl_q == CL_IDLE)) begin
            snap_d = live_count;
            unique case (acc_q)
                ACC_HI:   cl_d = CL_ONE_HI;
                ACC_WORD: cl_d = CL_PAIR_LO;
                default:  cl_d = CL_ONE_LO;
            endcase
        end

        if (sts_latch_req && !stv_q) begin
            sts_d = {out_lvl, 1'b0, acc_q, mode_q, bcd_q};
            stv_d = 1'b1;
        end

        if (data_re) begin
            if (stv_q) begin
                stv_d = 1'b0;
            end else begin
                unique case (cl_q)
                    CL_PAIR_LO: cl_d = CL_ONE_HI;
                    CL_ONE_LO,
                    CL_ONE_HI:  cl_d = CL_IDLE;
                    CL_IDLE: begin
                        if (acc_q == ACC_WORD)
                            rseq_d = (rseq_q == SEQ_FIRST) ? SEQ_SECOND : SEQ_FIRST;
                    end
                endcase
            end
        end
    end

    // Output process
    always_comb begin
        init_count = init_q;
        load_stb   = load_q;
        mode       = mode_q;
        bcd        = bcd_q;
        if (stv_q) begin
            rd_byte = sts_q;
        end else begin
            unique case (cl_q)
                CL_ONE_LO,
                CL_PAIR_LO: rd_byte = snap_q[BYTE_W-1:0];
                CL_ONE_HI:  rd_byte = snap_q[CNT_W-1:BYTE_W];
                CL_IDLE: begin
                    if (acc_q == ACC_HI ||
                        (acc_q == ACC_WORD && rseq_q == SEQ_SECOND))
                        rd_byte = live_count[CNT_W-1:BYTE_W];
                    else
                        rd_byte = live_count[BYTE_W-1:0];
                end
            endcase
        end
    end
endmodule

// File: rtl/tmr_read_mux.sv
module tmr_read_mux
    import tmr_pkg::*;
#(
    parameter int NCH = 3,
    parameter int AW  = 2
) (
    input  logic [AW-1:0]         bus_addr,
    input  logic [NCH*BYTE_W-1:0] ch_bytes,
    output logic [BYTE_W-1:0]     rdata
);
    always_comb begin
        rdata = '1;
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == AW'(i))
                rdata = ch_bytes[i*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/tmr_host_regs.sv
module tmr_host_regs
    import tmr_pkg::*;
#(
    parameter int NCH = 3,
    parameter int AW  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [BYTE_W-1:0]     bus_wdata,
    output logic [BYTE_W-1:0]     bus_rdata,
    output logic                  bus_rd_unused,
    output logic [NCH*CNT_W-1:0]  ch_init_count,
    output logic [NCH-1:0]        ch_load,
    output logic [NCH*MODE_W-1:0] ch_mode,
    output logic [NCH-1:0]        ch_bcd,
    input  logic [NCH*CNT_W-1:0]  ch_live_count,
    input  logic [NCH-1:0]        ch_out
);
    logic [NCH-1:0]        cfg_we;
    acc_e                  cfg_acc;
    logic [MODE_W-1:0]     cfg_mode;
    logic                  cfg_bcd;
    logic [NCH-1:0]        cnt_latch;
    logic [NCH-1:0]        sts_latch;
    logic [NCH-1:0]        data_we;
    logic [NCH-1:0]        data_re;
    logic [NCH*BYTE_W-1:0] ch_bytes;

    tmr_bus_decode #(.NCH(NCH), .AW(AW)) u_dec (
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .cfg_we    (cfg_we),
        .cfg_acc   (cfg_acc),
        .cfg_mode  (cfg_mode),
        .cfg_bcd   (cfg_bcd),
        .cnt_latch (cnt_latch),
        .sts_latch (sts_latch),
        .data_we   (data_we),
        .data_re   (data_re),
        .rd_unused (bus_rd_unused)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        tmr_chan_regs u_chan (
            .clk           (clk),
            .rst_n         (rst_n),
            .cfg_we        (cfg_we[i]),
            .cfg_acc       (cfg_acc),
            .cfg_mode      (cfg_mode),
            .cfg_bcd       (cfg_bcd),
            .cnt_latch_req (cnt_latch[i]),
            .sts_latch_req (sts_latch[i]),
            .data_we       (data_we[i]),
            .data_re       (data_re[i]),
            .wdata         (bus_wdata),
            .live_count    (ch_live_count[i*CNT_W +: CNT_W]),
            .out_lvl       (ch_out[i]),
            .init_count    (ch_init_count[i*CNT_W +: CNT_W]),
            .load_stb      (ch_load[i]),
            .mode          (ch_mode[i*MODE_W +: MODE_W]),
            .bcd           (ch_bcd[i]),
            .rd_byte       (ch_bytes[i*BYTE_W +: BYTE_W])
        );
    end

    tmr_read_mux #(.NCH(NCH), .AW(AW)) u_mux (
        .bus_addr (bus_addr),
        .ch_bytes (ch_bytes),
        .rdata    (bus_rdata)
    );
endmodule

// File: rtl/tmr_host_regs_chk.sv
module tmr_host_regs_chk
    import tmr_pkg::*;
#(
    parameter int NCH = 3,
    parameter int AW  = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [AW-1:0]         bus_addr,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [BYTE_W-1:0]     bus_rdata,
    input logic                  bus_rd_unused,
    input logic [NCH-1:0]        ch_load,
    input logic [NCH*MODE_W-1:0] ch_mode,
    input logic [NCH-1:0]        ch_bcd
);
    localparam logic [AW-1:0] CTRL_ADDR  = {AW{1'b1}};
    localparam logic [AW-1:0] FIRST_FREE = AW'(NCH);

    AST_UNUSED_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_unused |-> (bus_rdata == '1)); // R9

    AST_UNUSED_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == CTRL_ADDR) |=> (ch_load == '0)); // R9

    AST_LOAD_AFTER_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_load != '0) |-> $past(bus_wr && (bus_addr < FIRST_FREE))); // R2

    AST_LOAD_SINGLE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_load)); // R2

    AST_CONFIG_BY_CONTROL: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ch_mode) || !$stable(ch_bcd)) |->
            $past(bus_wr && bus_addr == CTRL_ADDR)); // R11
endmodule

bind tmr_host_regs tmr_host_regs_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_rdata     (bus_rdata),
    .bus_rd_unused (bus_rd_unused),
    .ch_load       (ch_load),
    .ch_mode       (ch_mode),
    .ch_bcd        (ch_bcd)
);

// File: tb/tmr_host_regs_tb.sv
`timescale 1ns/1ps
module tmr_host_regs_tb;
    localparam int NCH = 3;
    localparam int AW  = 2;
    localparam int CLK_HALF = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_rd_unused;
    logic [47:0] ch_init_count;
    logic [2:0]  ch_load;
    logic [8:0]  ch_mode;
    logic [2:0]  ch_bcd;
    logic [47:0] ch_live_count;
    logic [2:0]  ch_out = 3'b100;

    logic [2:0]  run = '0;
    logic [15:0] mdl [3];
    logic [15:0] wr_live [3];
    logic [15:0] rd_live;
    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #(CLK_HALF) clk = ~clk;

    tmr_host_regs #(.NCH(NCH), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rd_unused(bus_rd_unused), .ch_init_count(ch_init_count),
        .ch_load(ch_load), .ch_mode(ch_mode), .ch_bcd(ch_bcd),
        .ch_live_count(ch_live_count), .ch_out(ch_out)
    );

    // Counter model: loads on strobe, counts down when enabled
    always_ff @(posedge clk) begin
        for (int i = 0; i < 3; i++) begin
            if (!rst_n)
                mdl[i] <= (i == 0) ? 16'hA1B2 : (i == 1) ? 16'hC3D4 : 16'hE5F6;
            else if (ch_load[i])
                mdl[i] <= ch_init_count[i*16 +: 16];
            else if (run[i])
                mdl[i] <= mdl[i] - 16'd1;
        end
    end
    assign ch_live_count = {mdl[2], mdl[1], mdl[0]};

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        for (int i = 0; i < 3; i++) wr_live[i] = mdl[i];
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d, output logic u);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #5;
        d = bus_rdata; u = bus_rd_unused;
        rd_live = (a < 3) ? mdl[a] : 16'h0;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
        logic [7:0] d; logic u;
        rd(a, d, u);
        chk(d == exp && u == (a == 2'd3), req, {23'd0, u, d}, {23'd0, (a == 2'd3), exp});
    endtask

    // Vector table: op, addr, data, expected
    localparam logic [1:0] OP_W = 2'd0, OP_WL = 2'd1, OP_R = 2'd2, OP_WN = 2'd3;
    localparam int NV = 21;
    localparam logic [27:0] VEC [NV] = '{
        {OP_W,  2'd3, 8'h34, 16'h0000},  // R1 ch0 low-then-high, mode 2
        {OP_R,  2'd0, 8'h00, 16'h00B2},  // R4 live low
        {OP_R,  2'd0, 8'h00, 16'h00A1},  // R4 live high
        {OP_R,  2'd0, 8'h00, 16'h00B2},  // R4 alternation
        {OP_WN, 2'd0, 8'h78, 16'h0000},  // R3 first byte held
        {OP_WL, 2'd0, 8'h56, 16'h5678},  // R3 pair loads
        {OP_R,  2'd0, 8'h00, 16'h0056},  // R4 high (order continues)
        {OP_R,  2'd0, 8'h00, 16'h0078},  // R4 low
        {OP_W,  2'd3, 8'h50, 16'h0000},  // R1 ch1 low only
        {OP_R,  2'd1, 8'h00, 16'h00D4},  // R4
        {OP_R,  2'd1, 8'h00, 16'h00D4},  // R4 no alternation
        {OP_W,  2'd3, 8'hA6, 16'h0000},  // R1 ch2 high only, mode 3
        {OP_R,  2'd2, 8'h00, 16'h00E5},  // R4
        {OP_WL, 2'd2, 8'h9C, 16'h9C00},  // R2 high-only load
        {OP_R,  2'd2, 8'h00, 16'h009C},  // R4
        {OP_WL, 2'd1, 8'h3F, 16'h003F},  // R2 low-only load
        {OP_R,  2'd1, 8'h00, 16'h003F},  // R4
        {OP_R,  2'd3, 8'h00, 16'h00FF},  // R9 unused address
        {OP_W,  2'd3, 8'hE8, 16'h0000},  // R7 status of ch2
        {OP_R,  2'd2, 8'h00, 16'h00A6},  // R8 status byte
        {OP_R,  2'd2, 8'h00, 16'h009C}   // R8 then live
    };

    initial begin : main
        logic [1:0]  op, a;
        logic [7:0]  d;
        logic [15:0] e, snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        @(negedge clk);
        chk(ch_load == 3'b000, "R10 load", {29'd0, ch_load}, 0);
        chk(ch_mode == 9'd0 && ch_bcd == 3'd0, "R10 mode/bcd", {20'd0, ch_mode, ch_bcd}, 0);
        chk(ch_init_count == 48'd0, "R10 init", ch_init_count[31:0], 0);
        wr(2'd3, 8'hEE);                          // status of all channels
        rd_chk(2'd0, 8'h10, "R10 status ch0");
        rd_chk(2'd1, 8'h10, "R10 status ch1");
        rd_chk(2'd2, 8'h90, "R10 status ch2");
        rd_chk(2'd0, 8'hB2, "R10 live low-only");

        // table walk
        for (int k = 0; k < NV; k++) begin
            op = VEC[k][27:26]; a = VEC[k][25:24];
            d = VEC[k][23:16];  e = VEC[k][15:0];
            if (op == OP_R) begin
                rd_chk(a, e[7:0], $sformatf("R4/R8/R9 vec %0d", k));
            end else begin
                wr(a, d);
                if (op == OP_WL)
                    chk(ch_load == (3'b1 << a) && ch_init_count[a*16 +: 16] == e,
                        $sformatf("R2/R3 vec %0d", k),
                        {13'd0, ch_load, ch_init_count[a*16 +: 16]}, {13'd0, 3'b1 << a, e});
                else if (op == OP_WN)
                    chk(ch_load == 3'b000, $sformatf("R3 vec %0d", k), {29'd0, ch_load}, 0);
            end
        end

        // R1 mode and BCD outputs
        wr(2'd3, 8'h1B);
        chk(ch_mode[2:0] == 3'd5 && ch_bcd[0] && ch_mode[8:6] == 3'd3, "R1 mode/bcd",
            {20'd0, ch_mode, ch_bcd}, {20'd0, 3'd3, 3'd0, 3'd5, 3'b001});
        wr(2'd3, 8'h34);

        // R1 control word restarts write order
        wr(2'd0, 8'h11);
        wr(2'd3, 8'h34);
        wr(2'd0, 8'h22);
        chk(ch_load == 3'b000, "R1 held after restart", {29'd0, ch_load}, 0);
        wr(2'd0, 8'h33);
        chk(ch_load[0] && ch_init_count[15:0] == 16'h3322, "R1 write order restart",
            {15'd0, ch_load[0], ch_init_count[15:0]}, {15'd0, 1'b1, 16'h3322});
        rd_chk(2'd0, 8'h22, "R4 low");
        wr(2'd3, 8'h34);
        rd_chk(2'd0, 8'h22, "R1 read order restart");

        // R9 unused read leaves the read order alone
        rd_chk(2'd3, 8'hFF, "R9 unused");
        rd_chk(2'd0, 8'h33, "R9 order unchanged");

        // R5 / R6 latch against a running counter
        run[0] = 1'b1;
        repeat (3) @(negedge clk);
        wr(2'd3, 8'h00);
        snap = wr_live[0];
        repeat (5) @(negedge clk);
        wr(2'd3, 8'h00);                          // ignored, latch pending
        rd_chk(2'd0, snap[7:0],  "R5 frozen low");
        rd_chk(2'd0, snap[15:8], "R6 frozen high kept");
        begin
            logic [7:0] dd; logic uu;
            rd(2'd0, dd, uu);
            chk(dd == rd_live[7:0], "R5 released to live", {24'd0, dd}, {24'd0, rd_live[7:0]});
        end
        run[0] = 1'b0;

        // R7 / R8 read-back count and status on ch1
        ch_out[1] = 1'b1;
        wr(2'd3, 8'hC4);
        ch_out[1] = 1'b0;
        wr(2'd3, 8'hE4);                          // status pending: ignored
        run[1] = 1'b1;
        repeat (4) @(negedge clk);
        rd_chk(2'd1, 8'h90, "R7 status kept, R8 status first");
        rd_chk(2'd1, 8'h3F, "R8 frozen count second");
        begin
            logic [7:0] dd; logic uu;
            rd(2'd1, dd, uu);
            chk(dd == rd_live[7:0], "R5 live after frozen", {24'd0, dd}, {24'd0, rd_live[7:0]});
        end
        run[1] = 1'b0;

        // R7 selective read-back: ch0 and ch2 counts only
        wr(2'd3, 8'hDA);
        snap = wr_live[0];
        wr(2'd2, 8'h77);
        rd_chk(2'd2, 8'h9C, "R7 ch2 frozen");
        rd_chk(2'd2, 8'h77, "R7 ch2 live after");
        begin
            logic [7:0] dd; logic uu;
            rd(2'd1, dd, uu);
            chk(dd == rd_live[7:0], "R7 ch1 not selected", {24'd0, dd}, {24'd0, rd_live[7:0]});
        end
        rd_chk(2'd0, snap[7:0],  "R7 ch0 frozen low");
        rd_chk(2'd0, snap[15:8], "R7 ch0 frozen high");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule